// File: doc/BRIEF.md
# Nibble-Port Shared Byte RAM

This block holds a byte-wide memory that two agents share: an 8-bit host bus and a small microcontroller that sees the outside world only through 4-bit output registers and 4-bit input ports. An ownership flag, set by the host, decides which side may change the memory. The host can read at any time. Its writes land only while it owns the memory.

The microcontroller loads four nibble registers and a 4-bit control nibble through a single port-write strobe with a select code. Two register nibbles give the low eight address bits. Two control bits extend the address to ten bits. The other two register nibbles form the byte to store. Two more control bits form an active-low read enable and a write strobe. The write is level-sensitive: on every clock edge where the microcontroller owns the memory and both strobe bits are high, the byte from the registers is stored at the address from the registers. Moving the address or changing the data while the strobe stays high therefore writes again at the new place or value. A start input is passed to the microcontroller's interrupt line.

Top module: `nibble_shared_ram`

## Requirements
- R1: The memory has 1024 bytes. `host_rdata` shows, without a clock, the byte at `host_ofs[9:0]`. Bits above bit 9 of `host_ofs` are ignored.
- R2: While `rst_n` is low, the ownership flag, the four nibble registers and the control nibble are held at 0. Memory contents are kept through reset.
- R3: When the ownership flag is 0 and `host_we` is 1 at a clock edge, `host_wdata` is stored at `host_ofs[9:0]`. When the flag is 1, `host_we` changes nothing.
- R4: The microcontroller address is {control[1:0], nibble reg 2, nibble reg 3}, with register 3 as the least significant nibble.
- R5: The microcontroller write byte is {nibble reg 0, nibble reg 1}, with register 0 as the upper nibble.
- R6: On every clock edge where the ownership flag is 1 and control bits 3 and 2 are both 1, the write byte is stored at the microcontroller address. Both values are taken from the register contents before that edge, so a register change made at one edge is used from the following edge on.
- R7: When the ownership flag is 1 and control bit 2 is 0, the byte at the microcontroller address is presented on the read ports. Otherwise both read ports show 0.
- R8: `mcu_in_hi` carries the upper nibble of the presented byte and `mcu_in_lo` carries the lower nibble.
- R9: `mcu_irq` equals `start` while `rst_n` is high and is 0 while `rst_n` is low.
- R10: When `mcu_port_we` is 1 at a clock edge, `mcu_port_sel` picks the target: 0 to 3 load nibble registers 0 to 3, 4 loads the control nibble, and 5 to 7 change nothing.
- R11: When `dir_we` is 1 at a clock edge, the ownership flag takes `dir_val` (0 gives the host ownership, 1 gives the microcontroller ownership).
- R12: Setting the ownership flag to 1 while control bits 3 and 2 are already 1 starts writing from the edge after the flag changes. Clearing the flag stops the writing from the edge after it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ofs | input | 16 | Host offset; only the low 10 bits are used |
| host_we | input | 1 | Host write request |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte at the host offset |
| dir_we | input | 1 | Load the ownership flag |
| dir_val | input | 1 | New ownership flag value (1 = microcontroller) |
| start | input | 1 | Start request to the microcontroller |
| mcu_irq | output | 1 | Interrupt line to the microcontroller |
| mcu_port_we | input | 1 | Microcontroller port-register write strobe |
| mcu_port_sel | input | 3 | Port-register select (0-3 nibble regs, 4 control) |
| mcu_port_wdata | input | 4 | Nibble to load |
| mcu_in_hi | output | 4 | Read port, upper nibble |
| mcu_in_lo | output | 4 | Read port, lower nibble |

## Verification
The hardest case to reach is a write strobe that stays high while the address or data registers are reloaded underneath it. This should leave a trail of stores across several locations, one per edge. The host would see that trail only if it looks at the right bytes. The bench holds the strobe bits in the control nibble while it reloads address nibbles one per cycle. It also toggles ownership with the strobe already set. A behavioural model keeps its own copy of all 1024 bytes, and every stray or missing store shows up when the host reads that offset later. A long random phase weights control nibbles toward the strobe pattern so that these overlaps happen often.

// File: rtl/nibble_shared_ram.sv
module nibble_shared_ram #(
  parameter int NW    = 4,
  parameter int HOFSW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HOFSW-1:0] host_ofs,
  input  logic             host_we,
  input  logic [2*NW-1:0]  host_wdata,
  output logic [2*NW-1:0]  host_rdata,
  input  logic             dir_we,
  input  logic             dir_val,
  input  logic             start,
  output logic             mcu_irq,
  input  logic             mcu_port_we,
  input  logic [2:0]       mcu_port_sel,
  input  logic [NW-1:0]    mcu_port_wdata,
  output logic [NW-1:0]    mcu_in_hi,
  output logic [NW-1:0]    mcu_in_lo
);
  localparam int DW    = 2 * NW;
  localparam int AW    = 2 * NW + 2;
  localparam int DEPTH = 1 << AW;
  localparam int NREG  = 4;

  logic [DW-1:0] mem [DEPTH];
  logic [NW-1:0] nreg [NREG];
  logic [NW-1:0] ctl_q;
  logic          dir_q;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_nreg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) nreg[g] <= '0;
        else if (mcu_port_we && mcu_port_sel == 3'(g)) nreg[g] <= mcu_port_wdata;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl_q <= '0;
    else if (mcu_port_we && mcu_port_sel == 3'd4) ctl_q <= mcu_port_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dir_q <= 1'b0;
    else if (dir_we) dir_q <= dir_val;

  logic [AW-1:0] mcu_addr, host_addr, wr_addr;
  logic [DW-1:0] mcu_byte, wr_data, rd_byte;
  logic          mcu_wr, host_wr, mcu_rd;

  assign mcu_addr  = {ctl_q[1:0], nreg[2], nreg[3]};
  assign mcu_byte  = {nreg[0], nreg[1]};
  assign host_addr = host_ofs[AW-1:0];
  assign mcu_wr    = dir_q & ctl_q[3] & ctl_q[2];
  assign host_wr   = ~dir_q & host_we;
  assign mcu_rd    = dir_q & ~ctl_q[2];
  assign wr_addr   = mcu_wr ? mcu_addr : host_addr;
  assign wr_data   = mcu_wr ? mcu_byte : host_wdata;

  always_ff @(posedge clk)
    if (mcu_wr || host_wr) mem[wr_addr] <= wr_data;

  assign host_rdata = mem[host_addr];
  assign rd_byte    = mcu_rd ? mem[mcu_addr] : '0;
  assign mcu_in_hi  = rd_byte[DW-1:NW];
  assign mcu_in_lo  = rd_byte[NW-1:0];
  assign mcu_irq    = rst_n & start;

  assert_host_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_q && host_we) |=> (host_rdata == $past(host_wdata)) ||
                            (host_addr != $past(host_addr)));

  assert_host_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q && host_we && !mcu_wr) |=> (host_rdata == $past(host_rdata)) ||
                                      (host_addr != $past(host_addr)));

  assert_level_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_wr && host_addr == mcu_addr) |=> (host_rdata == $past(mcu_byte)) ||
                                          (host_addr != $past(host_addr)));

  assert_read_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_q || ctl_q[2]) |-> (mcu_in_hi == '0 && mcu_in_lo == '0));

  assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mcu_irq == start);
endmodule

// File: tb/nibble_shared_ram_bench.sv
module nibble_shared_ram_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] host_ofs = '0;
  logic        host_we = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        dir_we = 1'b0, dir_val = 1'b0, start = 1'b0;
  logic        mcu_irq;
  logic        mcu_port_we = 1'b0;
  logic [2:0]  mcu_port_sel = '0;
  logic [3:0]  mcu_port_wdata = '0;
  logic [3:0]  mcu_in_hi, mcu_in_lo;

  nibble_shared_ram u_nibble_shared_ram (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit checking = 1'b0;

  logic [7:0] mm [1024];
  logic [3:0] m_r [4];
  logic [3:0] m_d;
  logic       m_dir;

  // behavioural reference: stores use pre-edge register contents (R6, R12)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_r[i] = 4'h0;   // R2
      m_d = 4'h0; m_dir = 1'b0;
    end else begin
      if (m_dir && m_d[3] && m_d[2])
        mm[{m_d[1:0], m_r[2], m_r[3]}] = {m_r[0], m_r[1]};   // R4 R5 R6
      else if (!m_dir && host_we)
        mm[host_ofs[9:0]] = host_wdata;                      // R3
      if (mcu_port_we) begin                                 // R10
        if (mcu_port_sel < 3'd4) m_r[mcu_port_sel[1:0]] = mcu_port_wdata;
        else if (mcu_port_sel == 3'd4) m_d = mcu_port_wdata;
      end
      if (dir_we) m_dir = dir_val;                           // R11
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp_v, cyc);
    end
  endtask

  task automatic compare();
    logic [7:0] eb;
    eb = (m_dir && !m_d[2]) ? mm[{m_d[1:0], m_r[2], m_r[3]}] : 8'h00;
    chk(host_rdata === mm[host_ofs[9:0]], "R1/R3/R6 host_rdata", host_rdata, mm[host_ofs[9:0]]);
    chk(mcu_in_hi === eb[7:4], "R7/R8 mcu_in_hi", mcu_in_hi, eb[7:4]);
    chk(mcu_in_lo === eb[3:0], "R7/R8 mcu_in_lo", mcu_in_lo, eb[3:0]);
    chk(mcu_irq === (rst_n & start), "R9 mcu_irq", mcu_irq, rst_n & start);
  endtask

  always @(negedge clk) begin
    cyc++;
    #1;
    if (checking) compare();
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle();
    host_we = 0; dir_we = 0; mcu_port_we = 0;
  endtask

  task automatic put(input int sel, input int val);
    @(negedge clk); idle();
    mcu_port_we = 1; mcu_port_sel = 3'(sel); mcu_port_wdata = 4'(val);
  endtask

  task automatic set_dir(input bit v);
    @(negedge clk); idle(); dir_we = 1; dir_val = v;
  endtask

  initial begin
    // R2 R9: irq low and read ports 0 during reset even with start high
    start = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk(mcu_irq === 1'b0, "R9 irq in reset", mcu_irq, 0);
    chk(mcu_in_hi === 4'h0 && mcu_in_lo === 4'h0, "R2 ports in reset", {mcu_in_hi, mcu_in_lo}, 0);
    rst_n = 1'b1; start = 1'b0;
    // fill memory through the host (R3), upper offset bits set (R1)
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk); idle();
      host_we = 1; host_ofs = 16'(i) | 16'hA400; host_wdata = 8'(i * 37 + 5);
    end
    @(negedge clk); idle();
    checking = 1'b1;

    // R4 R5 R6 R10: address 0x13C, byte 0xA5
    put(0, 4'hA); put(1, 4'h5); put(2, 4'h3); put(3, 4'hC);
    put(4, 4'b1101);
    set_dir(1);
    @(negedge clk); idle();
    put(4, 4'b0001);       // read enable active, strobe off
    @(negedge clk); idle(); #2;
    chk(mcu_in_hi === 4'hA && mcu_in_lo === 4'h5, "R6 stored byte", {mcu_in_hi, mcu_in_lo}, 8'hA5);
    // R3: host write blocked while microcontroller owns memory
    @(negedge clk); idle(); host_we = 1; host_ofs = 16'h013C; host_wdata = 8'h77;
    @(negedge clk); idle(); #2;
    chk(host_rdata === 8'hA5, "R3 host write ignored", host_rdata, 8'hA5);
    // R10: select codes 5..7 are ignored
    put(5, 4'hF); put(6, 4'hF); put(7, 4'hF);
    @(negedge clk); idle(); #2;
    chk(mcu_in_hi === 4'hA && mcu_in_lo === 4'h5, "R10 unused select", {mcu_in_hi, mcu_in_lo}, 8'hA5);
    // R6: strobe held while address nibble walks
    put(4, 4'b1100);
    for (int k = 0; k < 6; k++) put(3, k);
    // R12: toggle ownership with strobe still set
    set_dir(0); set_dir(1); set_dir(0);
    @(negedge clk); idle();

    // random phase, strobe pattern weighted
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk); idle();
      start    = $urandom_range(0, 1);
      host_ofs = 16'($urandom);
      host_we  = ($urandom_range(0, 2) == 0);
      host_wdata = 8'($urandom);
      if ($urandom_range(0, 15) == 0) begin dir_we = 1; dir_val = $urandom_range(0, 1); end
      if ($urandom_range(0, 1) == 0) begin
        mcu_port_we = 1;
        mcu_port_sel = 3'($urandom_range(0, 7));
        mcu_port_wdata = ($urandom_range(0, 2) == 0) ? 4'($urandom | 32'hC) : 4'($urandom);
      end
      if (n == 3000) begin
        // R2: mid-run reset keeps memory
        rst_n = 1'b0; #3; rst_n = 1'b1;
      end
    end
    // sweep host reads over the whole memory (R1, R6 trail)
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk); idle(); host_ofs = 16'(i);
    end
    @(negedge clk); idle();
    checking = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule